// File: doc/BRIEF.md
# Lockable Comparator Control Register Pair

This block holds the configuration of two analog comparator channels, A and B, in two 32-bit registers behind a minimal register bus. A write is taken in one clock cycle and a read is combinational. Every stored field is driven straight out to the analog and signal-conditioning logic: enable, plus-input select, minus-input select, window routing, window output, polarity, hysteresis, power mode and blanking select. The read path also returns each channel's live conditioned output, which the block receives as an input.

Each register has a protection bit. Software sets it once the channel is configured. From then on the whole register refuses writes, and that includes the protection bit itself, so only a reset brings the channel back to a writable state. This keeps a safety-related comparator setup in place when a stray bus write occurs. A parameter removes the window feature. When it does, the two window bits are tied to zero.

Top module: `cmp_ctrl_regs`

## Requirements
- R1: After reset, both registers read 0x00000000 apart from the live status bit, and every field output is zero.
- R2: A write to offset 0x00 (channel A) or 0x04 (channel B) loads the fields in the next cycle, and the same values appear at the field outputs. The bit positions are: enable [0], minus-input select [7:4], plus-input select [10:8], window routing [11], window output [14], polarity [15], hysteresis [17:16], power mode [19:18], blanking select [24:20] and lock [31].
- R3: While a channel's bit 31 reads 1, writes to that register leave every field unchanged, bit 31 included.
- R4: Only reset clears the lock. Once reset is released, the register is writable again.
- R5: Bit 30 always reads the channel's live status input, and writes to bit 30 have no effect.
- R6: Bits 29:25, 13:12 and 3:1 read zero and ignore writes. For channel B, bit 10 is also reserved and its plus-input select is 2 bits wide at [9:8].
- R7: A read from any offset other than 0x00 or 0x04 returns zero, and a write to such an offset changes neither register.
- R8: Locking one channel or writing to it has no effect on the other channel's register.
- R9: With the window feature disabled by parameter, bits 14 and 11 read zero and the matching outputs stay zero whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears both registers, including the locks |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| stat_a | input | 1 | Live conditioned output of channel A |
| stat_b | input | 1 | Live conditioned output of channel B |
| a_en | output | 1 | Channel A enable |
| a_inm_sel | output | 4 | Channel A minus-input select |
| a_inp_sel | output | 3 | Channel A plus-input select |
| a_win_route | output | 1 | Channel A takes channel B's plus input |
| a_win_out | output | 1 | Channel A output is the XOR of both channels |
| a_pol | output | 1 | Channel A output inversion |
| a_hyst | output | 2 | Channel A hysteresis: 0 none, 1 low, 2 medium, 3 high |
| a_pwr | output | 2 | Channel A power: 0 fast, 1 and 2 medium, 3 ultra-low |
| a_blank | output | 5 | Channel A blanking source select |
| a_lock | output | 1 | Channel A write protection active |
| b_en | output | 1 | Channel B enable |
| b_inm_sel | output | 4 | Channel B minus-input select |
| b_inp_sel | output | 2 | Channel B plus-input select |
| b_win_route | output | 1 | Channel B takes channel A's plus input |
| b_win_out | output | 1 | Channel B output is the XOR of both channels |
| b_pol | output | 1 | Channel B output inversion |
| b_hyst | output | 2 | Channel B hysteresis |
| b_pwr | output | 2 | Channel B power mode |
| b_blank | output | 5 | Channel B blanking source select |
| b_lock | output | 1 | Channel B write protection active |

## Verification
A corrupted register shows on the field outputs in the cycle after the faulty write and on the very next read of its offset. A lock that fails to hold shows as a field change on the first write that follows the lock. A lock that leaks across channels shows as a missed update on the other channel's next write. Each random write is followed by a readback of both offsets and a comparison of all field outputs, so any such fault is seen within two cycles.

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs #(
  parameter int ADDR_W = 8,
  parameter bit WINDOW_EN = 1'b1,
  parameter logic [ADDR_W-1:0] OFFS_A = 'h0,
  parameter logic [ADDR_W-1:0] OFFS_B = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              stat_a,
  input  logic              stat_b,
  output logic              a_en,
  output logic [3:0]        a_inm_sel,
  output logic [2:0]        a_inp_sel,
  output logic              a_win_route,
  output logic              a_win_out,
  output logic              a_pol,
  output logic [1:0]        a_hyst,
  output logic [1:0]        a_pwr,
  output logic [4:0]        a_blank,
  output logic              a_lock,
  output logic              b_en,
  output logic [3:0]        b_inm_sel,
  output logic [1:0]        b_inp_sel,
  output logic              b_win_route,
  output logic              b_win_out,
  output logic              b_pol,
  output logic [1:0]        b_hyst,
  output logic [1:0]        b_pwr,
  output logic [4:0]        b_blank,
  output logic              b_lock
);

  localparam logic [31:0] WIN_BITS = 32'h0000_4800;
  localparam logic [31:0] KEEP_A   = 32'h81FF_CFF1;
  localparam logic [31:0] KEEP_B   = 32'h81FF_CBF1;
  localparam logic [31:0] MASK_A   = WINDOW_EN ? KEEP_A : (KEEP_A & ~WIN_BITS);
  localparam logic [31:0] MASK_B   = WINDOW_EN ? KEEP_B : (KEEP_B & ~WIN_BITS);

  logic [31:0] reg_a_q, reg_b_q;
  logic        sel_a, sel_b, wr_a, wr_b;

  assign sel_a = (bus_addr == OFFS_A);
  assign sel_b = (bus_addr == OFFS_B);
  assign wr_a  = bus_we & sel_a & ~reg_a_q[31];
  assign wr_b  = bus_we & sel_b & ~reg_b_q[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a_q <= '0;
      reg_b_q <= '0;
    end else begin
      if (wr_a) reg_a_q <= bus_wdata & MASK_A;
      if (wr_b) reg_b_q <= bus_wdata & MASK_B;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_a)      bus_rdata = reg_a_q | {1'b0, stat_a, 30'b0};
    else if (sel_b) bus_rdata = reg_b_q | {1'b0, stat_b, 30'b0};
  end

  assign a_lock      = reg_a_q[31];
  assign a_blank     = reg_a_q[24:20];
  assign a_pwr       = reg_a_q[19:18];
  assign a_hyst      = reg_a_q[17:16];
  assign a_pol       = reg_a_q[15];
  assign a_win_out   = reg_a_q[14];
  assign a_win_route = reg_a_q[11];
  assign a_inp_sel   = reg_a_q[10:8];
  assign a_inm_sel   = reg_a_q[7:4];
  assign a_en        = reg_a_q[0];

  assign b_lock      = reg_b_q[31];
  assign b_blank     = reg_b_q[24:20];
  assign b_pwr       = reg_b_q[19:18];
  assign b_hyst      = reg_b_q[17:16];
  assign b_pol       = reg_b_q[15];
  assign b_win_out   = reg_b_q[14];
  assign b_win_route = reg_b_q[11];
  assign b_inp_sel   = reg_b_q[9:8];
  assign b_inm_sel   = reg_b_q[7:4];
  assign b_en        = reg_b_q[0];

endmodule

// File: rtl/cmp_ctrl_regs_chk.sv
module cmp_ctrl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter bit WINDOW_EN = 1'b1,
  parameter logic [ADDR_W-1:0] OFFS_A = 'h0,
  parameter logic [ADDR_W-1:0] OFFS_B = 'h4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic              stat_a,
  input logic              stat_b,
  input logic [22:0]       a_fields,
  input logic [21:0]       b_fields,
  input logic              a_lock,
  input logic              b_lock,
  input logic [1:0]        win_bits
);

  AST_LOCK_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    a_lock |=> a_lock); // R4
  AST_LOCK_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    b_lock |=> b_lock); // R4
  AST_LOCK_A_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    a_lock |=> $stable(a_fields)); // R3
  AST_LOCK_B_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    b_lock |=> $stable(b_fields)); // R3
  AST_A_WRITE_SPARES_B: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFFS_A) |=> ($stable(b_fields) && $stable(b_lock))); // R8
  AST_B_WRITE_SPARES_A: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFFS_B) |=> ($stable(a_fields) && $stable(a_lock))); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[29:25] == 5'd0 && bus_rdata[13:12] == 2'd0 && bus_rdata[3:1] == 3'd0)); // R6
  AST_STATUS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFFS_A) |-> (bus_rdata[30] == stat_a)); // R5
  AST_STATUS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFFS_B) |-> (bus_rdata[30] == stat_b)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != OFFS_A && bus_addr != OFFS_B) |-> (bus_rdata == 32'd0)); // R7
  AST_WIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!WINDOW_EN) |-> (win_bits == 2'b00)); // R9

endmodule

bind cmp_ctrl_regs cmp_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .WINDOW_EN(WINDOW_EN), .OFFS_A(OFFS_A), .OFFS_B(OFFS_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .stat_a(stat_a), .stat_b(stat_b),
  .a_fields({a_blank, a_pwr, a_hyst, a_pol, a_win_out, a_win_route, a_inp_sel, a_inm_sel, a_en}),
  .b_fields({b_blank, b_pwr, b_hyst, b_pol, b_win_out, b_win_route, b_inp_sel, b_inm_sel, b_en}),
  .a_lock(a_lock), .b_lock(b_lock),
  .win_bits({a_win_out | b_win_out, a_win_route | b_win_route})
);

// File: tb/tb_cmp_ctrl_regs.sv
module tb_cmp_ctrl_regs;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0, rdata, rdata_nw;
  logic stat_a = 0, stat_b = 0;
  logic a_en, a_win_route, a_win_out, a_pol, a_lock;
  logic [3:0] a_inm_sel; logic [2:0] a_inp_sel;
  logic [1:0] a_hyst, a_pwr; logic [4:0] a_blank;
  logic b_en, b_win_route, b_win_out, b_pol, b_lock;
  logic [3:0] b_inm_sel; logic [1:0] b_inp_sel;
  logic [1:0] b_hyst, b_pwr; logic [4:0] b_blank;
  logic n_a_en, n_a_wr, n_a_wo, n_a_pol, n_a_lock;
  logic [3:0] n_a_inm; logic [2:0] n_a_inp;
  logic [1:0] n_a_hyst, n_a_pwr; logic [4:0] n_a_blank;
  logic n_b_en, n_b_wr, n_b_wo, n_b_pol, n_b_lock;
  logic [3:0] n_b_inm; logic [1:0] n_b_inp;
  logic [1:0] n_b_hyst, n_b_pwr; logic [4:0] n_b_blank;

  int checks = 0, fails = 0;
  logic [31:0] ma = 0, mb = 0, na = 0, nb = 0;

  always #5 clk = ~clk;

  cmp_ctrl_regs dut (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata(rdata),
    .stat_a, .stat_b, .a_en, .a_inm_sel, .a_inp_sel, .a_win_route, .a_win_out, .a_pol,
    .a_hyst, .a_pwr, .a_blank, .a_lock, .b_en, .b_inm_sel, .b_inp_sel, .b_win_route,
    .b_win_out, .b_pol, .b_hyst, .b_pwr, .b_blank, .b_lock);

  cmp_ctrl_regs #(.WINDOW_EN(1'b0)) dut_nw (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata,
    .bus_rdata(rdata_nw), .stat_a, .stat_b, .a_en(n_a_en), .a_inm_sel(n_a_inm),
    .a_inp_sel(n_a_inp), .a_win_route(n_a_wr), .a_win_out(n_a_wo), .a_pol(n_a_pol),
    .a_hyst(n_a_hyst), .a_pwr(n_a_pwr), .a_blank(n_a_blank), .a_lock(n_a_lock),
    .b_en(n_b_en), .b_inm_sel(n_b_inm), .b_inp_sel(n_b_inp), .b_win_route(n_b_wr),
    .b_win_out(n_b_wo), .b_pol(n_b_pol), .b_hyst(n_b_hyst), .b_pwr(n_b_pwr),
    .b_blank(n_b_blank), .b_lock(n_b_lock));

  function automatic logic [31:0] upd(logic [31:0] old, logic [31:0] d, logic [31:0] m);
    return old[31] ? old : (d & m);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    if (a == 8'h00) begin ma = upd(ma, d, 32'h81FFCFF1); na = upd(na, d, 32'h81FF87F1); end
    if (a == 8'h04) begin mb = upd(mb, d, 32'h81FFCBF1); nb = upd(nb, d, 32'h81FF83F1); end
  endtask

  task automatic verify(string req);
    bus_addr = 8'h00; #1;
    chk(req, rdata, ma | {1'b0, stat_a, 30'b0});
    chk({req, " R9"}, rdata_nw, na | {1'b0, stat_a, 30'b0});
    bus_addr = 8'h04; #1;
    chk(req, rdata, mb | {1'b0, stat_b, 30'b0});
    chk({req, " R9"}, rdata_nw, nb | {1'b0, stat_b, 30'b0});
    chk({req, " R2 outA"}, {a_lock, 6'b0, a_blank, a_pwr, a_hyst, a_pol, a_win_out, 2'b0,
      a_win_route, a_inp_sel, a_inm_sel, 3'b0, a_en}, ma);
    chk({req, " R2 outB"}, {b_lock, 6'b0, b_blank, b_pwr, b_hyst, b_pol, b_win_out, 2'b0,
      b_win_route, 1'b0, b_inp_sel, b_inm_sel, 3'b0, b_en}, mb);
    chk({req, " R9 out"}, {30'b0, n_a_wo | n_b_wo, n_a_wr | n_b_wr}, 32'b0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    ma = 0; mb = 0; na = 0; nb = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12; verify("R1 reset");
    @(negedge clk); rst_n = 1;
    verify("R1 after release");
    wr(8'h00, 32'h7FFF_FFFF); verify("R2 R6 all-ones A");
    wr(8'h04, 32'h7FFF_FFFF); verify("R2 R6 all-ones B");
    stat_a = 1; verify("R5 status A");
    wr(8'h00, 32'h4000_0000); verify("R5 write status bit");
    wr(8'h08, 32'hFFFF_FFFF); verify("R7 unmapped write");
    bus_addr = 8'h08; #1; chk("R7 unmapped read", rdata, 32'h0);
    bus_addr = 8'hFC; #1; chk("R7 unmapped read", rdata, 32'h0);
    wr(8'h00, 32'h8012_3451); verify("R3 lock A");
    wr(8'h00, 32'h0000_0000); verify("R3 locked write A");
    wr(8'h04, 32'h0155_4A31); verify("R8 B writable while A locked");
    do_reset(); verify("R4 reset clears lock");
    wr(8'h00, 32'h0000_0101); verify("R4 writable after reset");
    wr(8'h04, 32'h8000_0000); wr(8'h00, 32'h00AA_0070); verify("R8 A free while B locked");
    wr(8'h04, 32'h7FFF_FFFF); verify("R3 locked write B");
    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      logic [7:0] a;
      d = $urandom;
      if ($urandom_range(0, 30) != 0) d[31] = 1'b0;
      case ($urandom_range(0, 3))
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h08;
        default: a = 8'($urandom);
      endcase
      stat_a = 1'($urandom); stat_b = 1'($urandom);
      wr(a, d);
      verify("R2 R3 R8 random");
      if (i % 100 == 99) do_reset();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule